// File: doc/BRIEF.md
# Fly-by Lane Delay Checker

The block judges a set of per-byte-lane delay values produced by a leveling pass on a fly-by memory topology. A fly-by route reaches the byte lanes one after another, so trained delays should move in one direction across the lanes, and neighbouring lanes should differ by only a small amount. The block takes nine 6-bit lane delays (eight data lanes plus the ECC lane) and a check strobe. One clock later it reports pass or fail, why the first offending neighbour pair failed, and which pair it was. It does not correct the values or restart leveling.

Two checks run in parallel on each neighbour pair (lane i, lane i+1). The direction check takes the direction of the lowest pair whose delays differ, and flags any later differing pair that goes the other way. Equal neighbours never break the direction. The step check flags a pair whose absolute difference is above a programmable limit. Each check can be turned off on its own: one input bit removes the direction check, and a limit of zero removes the step check. Firmware typically programs a limit of 2.

The control is a two-state machine. IDLE means no fresh result this cycle. DONE means the registered result was taken from the previous cycle's strobe. The transitions are IDLE to DONE on a strobe, DONE to DONE on a further strobe, DONE to IDLE without one, and IDLE to IDLE without one.

Top module: `lvl_flyby_chk`

## Requirements
- R1: `res_valid` is high in exactly the cycle after each cycle in which `chk_stb` was sampled high. Back-to-back strobes give back-to-back valid cycles. After reset `res_valid`, `res_pass`, `res_cause` and `res_lane` are all 0.
- R2: Lane k's delay occupies bits [6k+5:6k] of `lane_dly`, for lanes 0 to 8. Lane 8 is the ECC lane and is checked like the others.
- R3: The reference direction is taken from the lowest-index pair whose two delays differ: up if the higher lane holds the larger delay. Pairs with equal delays never count as a direction violation, and a vector of all-equal delays passes.
- R4: A pair whose delays differ and whose direction is opposite to the reference direction is a direction violation, reported with cause code 1.
- R5: While `trend_off` is 1 when sampled with the strobe, no direction violation is reported.
- R6: A pair whose absolute delay difference is strictly greater than `step_max` is a step violation, reported with cause code 2. A difference equal to `step_max` is not a violation.
- R7: A `step_max` of 0 disables the step check.
- R8: On failure, `res_pass` is 0 and `res_lane` is the lowest index i such that pair (i, i+1) has any violation.
- R9: When the reported pair has both violations, the cause code is 1 (direction wins over step).
- R10: On a pass, `res_pass` is 1, `res_cause` is 0 and `res_lane` is 0.
- R11: `res_pass`, `res_cause` and `res_lane` hold their last result until the next strobe. Input changes without a strobe have no effect on them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chk_stb | input | 1 | Sample the lane delays and configuration and judge them |
| lane_dly | input | 54 | Nine packed 6-bit lane delays, lane 0 in the low bits |
| trend_off | input | 1 | 1 disables the direction check |
| step_max | input | 6 | Largest allowed neighbour difference; 0 disables the step check |
| res_valid | output | 1 | One-cycle pulse: result fields are fresh |
| res_pass | output | 1 | 1 when no pair violated an enabled check |
| res_cause | output | 2 | 0 none, 1 direction violation, 2 step violation |
| res_lane | output | 4 | Lower lane index of the first failing pair |

## Verification
The bench targets the cases where direction inference is easy to get wrong. It uses leading runs of equal lanes, where a design that sets the direction from pair 0 regardless would flag a correct vector. It also covers a reversal after a plateau, and a pair that is both reversed and oversized, where a design with the wrong priority would report code 2. Other runs place the difference exactly at the limit and one above it, which an off-by-one comparison would misjudge, and a jump confined to the ECC lane, which a design that skips lane 8 or slices the vector wrongly would miss. Further runs exercise several failing pairs, where a high-first encoder reports the wrong lane, and input changes without a strobe, where a design that recomputes combinationally would let the outputs drift.

// File: rtl/lvl_chk_pkg.sv
package lvl_chk_pkg;

    typedef enum logic [1:0] {
        CAUSE_NONE  = 2'd0,
        CAUSE_TREND = 2'd1,
        CAUSE_STEP  = 2'd2
    } cause_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_DONE = 1'b1
    } state_e;

endpackage

// File: rtl/lvl_pair_eval.sv
module lvl_pair_eval #(
    parameter int DLY_W = 6,
    parameter int LIM_W = 6
) (
    input  logic [DLY_W-1:0] dly_lo,
    input  logic [DLY_W-1:0] dly_hi,
    input  logic [LIM_W-1:0] step_max,
    output logic             ne,
    output logic             up,
    output logic             step_bad
);
    localparam int CW = (DLY_W > LIM_W) ? DLY_W : LIM_W;

    logic [DLY_W-1:0] mag;
    logic [CW-1:0]    mag_x;
    logic [CW-1:0]    lim_x;

    always_comb begin
        ne    = (dly_hi != dly_lo);
        up    = (dly_hi > dly_lo);
        mag   = up ? (dly_hi - dly_lo) : (dly_lo - dly_hi);
        mag_x = CW'(mag);
        lim_x = CW'(step_max);
        step_bad = (step_max != '0) && (mag_x > lim_x);
    end
endmodule

// File: rtl/lvl_dir_find.sv
module lvl_dir_find #(
    parameter int NPAIR = 8
) (
    input  logic [NPAIR-1:0] ne,
    input  logic [NPAIR-1:0] up,
    output logic             dir_up
);
    always_comb begin
        dir_up = 1'b0;
        for (int i = NPAIR - 1; i >= 0; i--) begin
            if (ne[i]) begin
                dir_up = up[i];
            end
        end
    end
endmodule

// File: rtl/lvl_fail_pick.sv
module lvl_fail_pick
    import lvl_chk_pkg::*;
#(
    parameter int NPAIR = 8,
    parameter int IDX_W = 4
) (
    input  logic [NPAIR-1:0] trend_bad,
    input  logic [NPAIR-1:0] step_bad,
    output logic             any_fail,
    output logic [IDX_W-1:0] fail_idx,
    output cause_e           fail_cause
);
    always_comb begin
        any_fail   = 1'b0;
        fail_idx   = '0;
        fail_cause = CAUSE_NONE;
        for (int i = NPAIR - 1; i >= 0; i--) begin
            if (trend_bad[i] || step_bad[i]) begin
                any_fail   = 1'b1;
                fail_idx   = IDX_W'(i);
                fail_cause = trend_bad[i] ? CAUSE_TREND : CAUSE_STEP;
            end
        end
    end
endmodule

// File: rtl/lvl_flyby_chk.sv
module lvl_flyby_chk
    import lvl_chk_pkg::*;
#(
    parameter int NUM_LANES = 9,
    parameter int DLY_W     = 6,
    parameter int LIM_W     = 6,
    localparam int NPAIR    = NUM_LANES - 1,
    localparam int IDX_W    = $clog2(NUM_LANES),
    localparam int VEC_W    = NUM_LANES * DLY_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chk_stb,
    input  logic [VEC_W-1:0] lane_dly,
    input  logic             trend_off,
    input  logic [LIM_W-1:0] step_max,
    output logic             res_valid,
    output logic             res_pass,
    output logic [1:0]       res_cause,
    output logic [IDX_W-1:0] res_lane
);
    logic [NPAIR-1:0] pr_ne;
    logic [NPAIR-1:0] pr_up;
    logic [NPAIR-1:0] pr_step_bad;
    logic [NPAIR-1:0] pr_trend_bad;
    logic             dir_up;
    logic             any_fail;
    logic [IDX_W-1:0] fail_idx;
    cause_e           fail_cause;

    state_e state_q, state_d;

    for (genvar g = 0; g < NPAIR; g++) begin : g_pair
        lvl_pair_eval #(
            .DLY_W (DLY_W),
            .LIM_W (LIM_W)
        ) u_pair (
            .dly_lo   (lane_dly[g*DLY_W +: DLY_W]),
            .dly_hi   (lane_dly[(g+1)*DLY_W +: DLY_W]),
            .step_max (step_max),
            .ne       (pr_ne[g]),
            .up       (pr_up[g]),
            .step_bad (pr_step_bad[g])
        );
        assign pr_trend_bad[g] = !trend_off && pr_ne[g] && (pr_up[g] != dir_up);
    end

    lvl_dir_find #(.NPAIR(NPAIR)) u_dir (
        .ne     (pr_ne),
        .up     (pr_up),
        .dir_up (dir_up)
    );

    lvl_fail_pick #(.NPAIR(NPAIR), .IDX_W(IDX_W)) u_pick (
        .trend_bad  (pr_trend_bad),
        .step_bad   (pr_step_bad),
        .any_fail   (any_fail),
        .fail_idx   (fail_idx),
        .fail_cause (fail_cause)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = chk_stb ? ST_DONE : ST_IDLE;
            ST_DONE: state_d = chk_stb ? ST_DONE : ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign res_valid = (state_q == ST_DONE);

    // result register, loaded only on a strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_pass  <= 1'b0;
            res_cause <= CAUSE_NONE;
            res_lane  <= '0;
        end else if (chk_stb) begin
            res_pass  <= !any_fail;
            res_cause <= any_fail ? fail_cause : CAUSE_NONE;
            res_lane  <= any_fail ? fail_idx : '0;
        end
    end
endmodule

// File: rtl/lvl_flyby_chk_sva.sv
module lvl_flyby_chk_sva #(
    parameter int NUM_LANES = 9,
    parameter int LIM_W     = 6,
    parameter int IDX_W     = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             chk_stb,
    input logic             trend_off,
    input logic [LIM_W-1:0] step_max,
    input logic             res_valid,
    input logic             res_pass,
    input logic [1:0]       res_cause,
    input logic [IDX_W-1:0] res_lane
);
    assert_valid_after_stb_R1: assert property (@(posedge clk) disable iff (!rst_n)
        chk_stb |=> res_valid);

    assert_no_valid_wo_stb_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_stb |=> !res_valid);

    assert_trend_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        chk_stb && trend_off |=> res_cause != 2'd1);

    assert_step_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        chk_stb && (step_max == '0) |=> res_cause != 2'd2);

    assert_lane_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && !res_pass |-> (res_lane < IDX_W'(NUM_LANES - 1)) &&
                                    (res_cause == 2'd1 || res_cause == 2'd2));

    assert_pass_clean_R10: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && res_pass |-> res_cause == 2'd0 && res_lane == '0);

    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_stb |=> $stable(res_pass) && $stable(res_cause) && $stable(res_lane));
endmodule

bind lvl_flyby_chk lvl_flyby_chk_sva #(
    .NUM_LANES (NUM_LANES),
    .LIM_W     (LIM_W),
    .IDX_W     (IDX_W)
) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .chk_stb   (chk_stb),
    .trend_off (trend_off),
    .step_max  (step_max),
    .res_valid (res_valid),
    .res_pass  (res_pass),
    .res_cause (res_cause),
    .res_lane  (res_lane)
);

// File: tb/tb_lvl_flyby_chk.sv
module tb_lvl_flyby_chk;
    localparam int CLK_PERIOD = 10;
    localparam int NL = 9;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        chk_stb = 1'b0;
    logic [53:0] lane_dly = '0;
    logic        trend_off = 1'b0;
    logic [5:0]  step_max = 6'd2;
    logic        res_valid;
    logic        res_pass;
    logic [1:0]  res_cause;
    logic [3:0]  res_lane;

    int n_checks = 0;
    int n_fail = 0;
    string cur_req = "R1";
    int lv[NL];

    // reference model state
    bit m_valid = 0;
    bit m_pass = 0;
    int m_cause = 0;
    int m_lane = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lvl_flyby_chk dut (
        .clk(clk), .rst_n(rst_n), .chk_stb(chk_stb), .lane_dly(lane_dly),
        .trend_off(trend_off), .step_max(step_max), .res_valid(res_valid),
        .res_pass(res_pass), .res_cause(res_cause), .res_lane(res_lane)
    );

    function automatic void judge(input logic [53:0] v, input bit toff, input int lim,
                                  output bit p, output int c, output int l);
        int d[NL];
        int dir;
        p = 1; c = 0; l = 0; dir = 0;
        for (int i = 0; i < NL; i++) d[i] = int'(v[6*i +: 6]);
        for (int i = 0; i < NL - 1; i++)
            if (dir == 0 && d[i+1] != d[i]) dir = (d[i+1] > d[i]) ? 1 : -1;
        for (int i = 0; i < NL - 1; i++) begin
            int df;
            bit tb, sb;
            df = d[i+1] - d[i];
            tb = !toff && df != 0 && ((df > 0) ? 1 : -1) != dir;
            sb = lim != 0 && ((df < 0) ? -df : df) > lim;
            if (p && (tb || sb)) begin
                p = 0; c = tb ? 1 : 2; l = i;
            end
        end
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_valid = 0; m_pass = 0; m_cause = 0; m_lane = 0;
        end else begin
            m_valid = chk_stb;
            if (chk_stb) judge(lane_dly, trend_off, int'(step_max), m_pass, m_cause, m_lane);
        end
    end

    task automatic check(input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", cur_req, what, act, exp);
        end
    endtask

    // compare on every falling edge
    always @(negedge clk) begin
        check("valid", int'(res_valid), int'(m_valid));
        check("pass",  int'(res_pass),  int'(m_pass));
        check("cause", int'(res_cause), m_cause);
        check("lane",  int'(res_lane),  m_lane);
    end

    function automatic logic [53:0] pack_lanes();
        logic [53:0] v;
        for (int i = 0; i < NL; i++) v[6*i +: 6] = 6'(lv[i]);
        return v;
    endfunction

    task automatic fire(input string req, input bit toff, input int lim);
        @(negedge clk);
        cur_req = req;
        lane_dly = pack_lanes();
        trend_off = toff;
        step_max = 6'(lim);
        chk_stb = 1'b1;
        @(negedge clk);
        chk_stb = 1'b0;
        @(negedge clk);
    endtask

    // direct checks against hand-computed values, sampled one cycle after strobe
    task automatic expect_res(input string req, input bit toff, input int lim,
                              input int p, input int c, input int l);
        @(negedge clk);
        cur_req = req;
        lane_dly = pack_lanes();
        trend_off = toff;
        step_max = 6'(lim);
        chk_stb = 1'b1;
        @(negedge clk);
        chk_stb = 1'b0;
        check("direct valid", int'(res_valid), 1);
        check("direct pass", int'(res_pass), p);
        check("direct cause", int'(res_cause), c);
        check("direct lane", int'(res_lane), l);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        cur_req = "R1";
        check("reset valid R1", int'(res_valid), 0);
        check("reset pass R1", int'(res_pass), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3: all equal passes; leading plateau then down
        lv = '{7, 7, 7, 7, 7, 7, 7, 7, 7};
        expect_res("R3", 0, 2, 1, 0, 0);
        lv = '{20, 20, 20, 19, 18, 18, 17, 16, 15};
        expect_res("R3", 0, 2, 1, 0, 0);
        // R10: increasing pass
        lv = '{1, 2, 4, 5, 7, 8, 10, 11, 13};
        expect_res("R10", 0, 2, 1, 0, 0);
        // R4: plateau, up, then reversal at pair 4
        lv = '{5, 5, 6, 7, 8, 7, 8, 9, 10};
        expect_res("R4", 0, 2, 0, 1, 4);
        // R5: same vector with direction check off passes
        expect_res("R5", 1, 2, 1, 0, 0);
        // R6: diff equal to limit passes, one above fails
        lv = '{0, 3, 6, 9, 12, 15, 18, 21, 24};
        expect_res("R6", 0, 3, 1, 0, 0);
        lv = '{0, 3, 6, 9, 13, 15, 18, 21, 24};
        expect_res("R6", 0, 3, 0, 2, 3);
        // R7: limit 0 ignores big jumps
        lv = '{0, 10, 30, 40, 50, 55, 60, 62, 63};
        expect_res("R7", 0, 0, 1, 0, 0);
        // R2: only the ECC lane jumps
        lv = '{4, 4, 4, 4, 4, 4, 4, 4, 40};
        expect_res("R2", 0, 2, 0, 2, 7);
        // R8: several failing pairs, lowest reported
        lv = '{10, 11, 12, 20, 21, 30, 31, 32, 33};
        expect_res("R8", 0, 2, 0, 2, 2);
        // R9: pair both reversed and oversized
        lv = '{10, 11, 12, 13, 5, 6, 7, 8, 9};
        expect_res("R9", 0, 2, 0, 1, 3);
        // R11: change inputs without strobe, outputs hold
        cur_req = "R11";
        lv = '{0, 0, 0, 0, 0, 0, 0, 0, 0};
        lane_dly = pack_lanes();
        trend_off = 1'b1;
        step_max = 6'd0;
        repeat (3) @(negedge clk);
        check("hold cause R11", int'(res_cause), 1);
        check("hold lane R11", int'(res_lane), 3);
        check("hold valid R11", int'(res_valid), 0);

        // R1: back-to-back strobes
        @(negedge clk);
        cur_req = "R1";
        lv = '{3, 3, 3, 3, 3, 3, 3, 3, 3};
        lane_dly = pack_lanes();
        chk_stb = 1'b1;
        @(negedge clk);
        check("b2b valid R1", int'(res_valid), 1);
        lv = '{3, 9, 3, 3, 3, 3, 3, 3, 3};
        lane_dly = pack_lanes();
        step_max = 6'd2;
        trend_off = 1'b0;
        @(negedge clk);
        chk_stb = 1'b0;
        check("b2b valid2 R1", int'(res_valid), 1);
        check("b2b cause R1", int'(res_cause), 2);

        // random sweeps compared against the model (R4 R6 R8)
        for (int k = 0; k < 300; k++) begin
            int base;
            base = $urandom_range(20, 40);
            for (int i = 0; i < NL; i++) lv[i] = base + $urandom_range(0, 6) - 3;
            if (k % 3 == 0)
                for (int i = 0; i < NL; i++) lv[i] = base + i * $urandom_range(0, 3);
            fire("R8", ($urandom_range(0, 3) == 0), $urandom_range(0, 4));
        end

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule